// File: doc/BRIEF.md
# Sensor Register Acquisition Sequencer

This block runs one complete measurement cycle on a capacitance-to-digital sensor that sits on a two-wire serial bus. It does not generate bus timing itself. It drives a byte-level bus engine through a simple command port. Each command is one of START (also used as a repeated start), WRITE of a byte, READ of a byte, or STOP. The engine answers every command with a one-cycle completion pulse. That pulse carries the slave's acknowledge for a WRITE and the received byte for a READ.

A start request launches the following phases, one after another:
- a sensor reset, sent as the single command byte 0xBE;
- a run of configuration register writes;
- repeated reads of the status register, continuing until its end-of-conversion bit reports ready;
- three 24-bit result reads, each taken as three consecutive bytes: capacitance X, then capacitance Y, then temperature.

The three results are presented together and marked by a one-cycle done pulse. If the slave refuses any byte the master sends, the block closes the bus with STOP, raises an error flag and returns to idle. The device address, the register addresses, the configuration values and the position and polarity of the ready bit are all parameters.

Top module: `acq_sequencer`

## Requirements
- R1: Command codes on `cmd_op_o` are 0 START, 1 WRITE, 2 READ and 3 STOP. `cmd_data_o` is zero for every code except WRITE. Once `cmd_valid_o` is raised, the op, data and nack fields hold steady until the cycle in which `eng_done_i` is high.
- R2: Every transaction begins with START followed by a WRITE of the address byte {DEV_ADDR, 0}. After a repeated START the address byte is {DEV_ADDR, 1}. Bit 0 of the address byte is the direction bit, with 0 meaning write and 1 meaning read.
- R3: A start request is accepted only while the block is idle. An accepted request runs the phases in a fixed order: reset, then configuration entries in index order, then status polls, then the X, Y and temperature result reads. A start request made while a run is in progress has no effect on the command stream.
- R4: The reset transaction is START, address for write, WRITE 0xBE, STOP.
- R5: Configuration entry i is START, address for write, WRITE of register byte i, WRITE of value byte i, STOP. Byte i of each packed parameter sits at bits [8i+7:8i].
- R6: A status poll is START, address for write, WRITE of the status pointer, START, address for read, one READ with nack set, STOP. Polling repeats until bit EOC_BIT of the status byte equals EOC_READY. By default this is bit 0 being low.
- R7: A result read is START, address for write, WRITE of the result pointer, START, address for read, three READs, STOP. Only the last of the three READs has `cmd_nack_o` set. The result pointers default to 0x01 for X, 0x04 for Y and 0x07 for temperature.
- R8: Result bytes are assembled most-significant first. The first byte read lands in bits 23:16 of the result.
- R9: All three result outputs update in the same cycle, and `done_o` is high for exactly that one cycle. That cycle is the one after the completion of the final STOP. At all other times the result outputs hold their values.
- R10: A WRITE completed with `eng_ack_i` low is followed directly by STOP, with no further bytes. The cycle after that STOP completes, `err_o` rises and the block returns to idle. No done pulse is given, and the result outputs are left unchanged.
- R11: `err_o` stays high until the next accepted start request. It clears in the cycle after that request is accepted.
- R12: After reset, `cmd_valid_o`, `done_o`, `err_o` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to run one acquisition cycle |
| cmd_valid_o | output | 1 | A command is presented to the bus engine |
| cmd_op_o | output | 2 | Command code: 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_data_o | output | 8 | Byte to send for WRITE, zero otherwise |
| cmd_nack_o | output | 1 | For READ, answer the byte with not-acknowledge |
| eng_done_i | input | 1 | One-cycle completion of the current command |
| eng_ack_i | input | 1 | Slave acknowledge of a WRITE, valid with eng_done_i |
| eng_rdata_i | input | 8 | Received byte of a READ, valid with eng_done_i |
| cap_x_o | output | 24 | Capacitance X result |
| cap_y_o | output | 24 | Capacitance Y result |
| temp_o | output | 24 | Temperature result |
| done_o | output | 1 | One-cycle pulse when new results are presented |
| err_o | output | 1 | Slave refused a byte in the last run |

## Verification
The hardest conditions to reach from the ports are a refused byte deep inside a run and a status bit that stays not-ready across several polls. The first case is a refusal on the read-address byte after the repeated start of a poll. The second case is a status byte whose other bits are set so that only the ready bit can end the loop. The bench's engine model counts every WRITE it sees and refuses the one with a chosen index. It also returns a programmable number of not-ready status bytes before a ready one. Its queue of expected commands is rewritten at the moment of refusal, so the exact point at which STOP must follow is pinned down. Engine latency changes between runs, and a stray start request is injected mid-run. Together these show that command holding and start filtering do not depend on timing.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    TX_CMD  = 2'd0,
    TX_WREG = 2'd1,
    TX_RREG = 2'd2
  } txn_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RST  = 3'd1,
    PH_CFG  = 3'd2,
    PH_POLL = 3'd3,
    PH_RES  = 3'd4
  } phase_e;

endpackage

// File: rtl/acq_rst_sync.sv
module acq_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/acq_txn_unit.sv
module acq_txn_unit
  import acq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int         MAX_RD   = 3,
  localparam int        RD_W     = $clog2(MAX_RD + 1),
  localparam int        STEP_W   = $clog2(MAX_RD + 7)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  txn_kind_e       kind_i,
  input  logic [7:0]      ptr_i,
  input  logic [7:0]      wdata_i,
  input  logic [RD_W-1:0] nrd_i,
  output logic            cmd_valid_o,
  output bus_op_e         cmd_op_o,
  output logic [7:0]      cmd_data_o,
  output logic            cmd_nack_o,
  input  logic            eng_done_i,
  input  logic            eng_ack_i,
  output logic            rbyte_valid_o,
  output logic            end_o,
  output logic            nack_o
);
  logic              active_q, fail_q;
  txn_kind_e         kind_q;
  logic [7:0]        ptr_q, wdata_q;
  logic [RD_W-1:0]   nrd_q;
  logic [STEP_W-1:0] step_q, last_step;

  bus_op_e    op;
  logic [7:0] data;
  logic       nack;

  // step decode: which command the current step presents
  always_comb begin
    op   = OP_STOP;
    data = 8'h00;
    nack = 1'b0;
    unique case (kind_q)
      TX_CMD:  last_step = STEP_W'(3);
      TX_WREG: last_step = STEP_W'(4);
      default: last_step = STEP_W'(5) + STEP_W'(nrd_q);
    endcase
    if (!fail_q && step_q != last_step) begin
      if (step_q == STEP_W'(0)) begin
        op = OP_START;
      end else if (step_q == STEP_W'(1)) begin
        op   = OP_WRITE;
        data = {DEV_ADDR, 1'b0};
      end else if (step_q == STEP_W'(2)) begin
        op   = OP_WRITE;
        data = ptr_q;
      end else if (kind_q == TX_WREG) begin
        op   = OP_WRITE;
        data = wdata_q;
      end else if (step_q == STEP_W'(3)) begin
        op = OP_START;
      end else if (step_q == STEP_W'(4)) begin
        op   = OP_WRITE;
        data = {DEV_ADDR, 1'b1};
      end else begin
        op   = OP_READ;
        nack = (step_q == last_step - STEP_W'(1));
      end
    end
  end

  logic adv_en;
  assign adv_en = active_q && eng_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fail_q   <= 1'b0;
      kind_q   <= TX_CMD;
      ptr_q    <= 8'h00;
      wdata_q  <= 8'h00;
      nrd_q    <= '0;
      step_q   <= '0;
    end else if (go_i && !active_q) begin
      active_q <= 1'b1;
      fail_q   <= 1'b0;
      kind_q   <= kind_i;
      ptr_q    <= ptr_i;
      wdata_q  <= wdata_i;
      nrd_q    <= nrd_i;
      step_q   <= '0;
    end else if (adv_en) begin
      if (op == OP_STOP)                    active_q <= 1'b0;
      else if (op == OP_WRITE && !eng_ack_i) fail_q  <= 1'b1;
      else                                   step_q  <= step_q + STEP_W'(1);
    end
  end

  assign cmd_valid_o   = active_q;
  assign cmd_op_o      = op;
  assign cmd_data_o    = data;
  assign cmd_nack_o    = nack;
  assign rbyte_valid_o = adv_en && (op == OP_READ);
  assign end_o         = adv_en && (op == OP_STOP);
  assign nack_o        = fail_q;
endmodule

// File: rtl/acq_byte_asm.sv
module acq_byte_asm #(
  parameter int  NBYTES = 3,
  localparam int WORD_W = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [7:0]        byte_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] acc_q;

  generate
    if (NBYTES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (push_i) acc_q <= byte_i;
      end
    end else begin : g_shift
      // earliest byte ends up in the top bits
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (push_i) acc_q <= {acc_q[WORD_W-9:0], byte_i};
      end
    end
  endgenerate

  assign word_o = acc_q;
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter logic [6:0]          DEV_ADDR  = 7'h48,
  parameter logic [7:0]          RST_CMD   = 8'hBE,
  parameter int                  NCFG      = 2,
  parameter logic [NCFG*8-1:0]   CFG_REGS  = 16'h0B0A,
  parameter logic [NCFG*8-1:0]   CFG_VALS  = 16'h01A0,
  parameter logic [7:0]          STAT_REG  = 8'h00,
  parameter int                  EOC_BIT   = 0,
  parameter logic                EOC_READY = 1'b0,
  parameter int                  RES_BYTES = 3,
  parameter logic [23:0]         RES_REGS  = 24'h070401
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  output logic                   cmd_valid_o,
  output logic [1:0]             cmd_op_o,
  output logic [7:0]             cmd_data_o,
  output logic                   cmd_nack_o,
  input  logic                   eng_done_i,
  input  logic                   eng_ack_i,
  input  logic [7:0]             eng_rdata_i,
  output logic [8*RES_BYTES-1:0] cap_x_o,
  output logic [8*RES_BYTES-1:0] cap_y_o,
  output logic [8*RES_BYTES-1:0] temp_o,
  output logic                   done_o,
  output logic                   err_o
);
  localparam int NRES  = 3;
  localparam int RES_W = 8 * RES_BYTES;
  localparam int RD_W  = $clog2(RES_BYTES + 1);
  localparam int IDX_N = (NCFG > NRES) ? NCFG : NRES;
  localparam int IDX_W = $clog2(IDX_N);

  logic rst_n_s;

  acq_rst_sync u_rst (.clk(clk), .rst_ni(rst_n), .rst_no(rst_n_s));

  // ---------------- transaction launch ----------------
  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             wait_q, wait_d;
  logic             err_q, err_d, done_q, done_d;
  logic             out_ld, sh_ld;

  logic             go;
  txn_kind_e        kind;
  logic [7:0]       ptr, wdata;
  logic [RD_W-1:0]  nrd;
  logic             txn_end, txn_nack, rbyte_valid;
  bus_op_e          op;
  logic [RES_W-1:0] word;

  assign go = (phase_q != PH_IDLE) && !wait_q;

  always_comb begin
    kind  = TX_CMD;
    ptr   = RST_CMD;
    wdata = 8'h00;
    nrd   = RD_W'(1);
    unique case (phase_q)
      PH_CFG: begin
        kind  = TX_WREG;
        ptr   = CFG_REGS[int'(idx_q)*8 +: 8];
        wdata = CFG_VALS[int'(idx_q)*8 +: 8];
      end
      PH_POLL: begin
        kind = TX_RREG;
        ptr  = STAT_REG;
      end
      PH_RES: begin
        kind = TX_RREG;
        ptr  = RES_REGS[int'(idx_q)*8 +: 8];
        nrd  = RD_W'(RES_BYTES);
      end
      default: ;
    endcase
  end

  acq_txn_unit #(.DEV_ADDR(DEV_ADDR), .MAX_RD(RES_BYTES)) u_txn (
    .clk(clk), .rst_n(rst_n_s), .go_i(go), .kind_i(kind), .ptr_i(ptr),
    .wdata_i(wdata), .nrd_i(nrd), .cmd_valid_o(cmd_valid_o), .cmd_op_o(op),
    .cmd_data_o(cmd_data_o), .cmd_nack_o(cmd_nack_o), .eng_done_i(eng_done_i),
    .eng_ack_i(eng_ack_i), .rbyte_valid_o(rbyte_valid), .end_o(txn_end),
    .nack_o(txn_nack)
  );

  assign cmd_op_o = op;

  acq_byte_asm #(.NBYTES(RES_BYTES)) u_asm (
    .clk(clk), .rst_n(rst_n_s), .push_i(rbyte_valid), .byte_i(eng_rdata_i),
    .word_o(word)
  );

  // ---------------- phase controller: next state ----------------
  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    wait_d  = wait_q;
    err_d   = err_q;
    done_d  = 1'b0;
    out_ld  = 1'b0;
    sh_ld   = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_d = PH_RST;
        idx_d   = '0;
        err_d   = 1'b0;
      end
    end else if (!wait_q) begin
      wait_d = 1'b1;
    end else if (txn_end) begin
      wait_d = 1'b0;
      if (txn_nack) begin
        phase_d = PH_IDLE;
        err_d   = 1'b1;
      end else begin
        unique case (phase_q)
          PH_RST: begin
            phase_d = PH_CFG;
            idx_d   = '0;
          end
          PH_CFG: begin
            if (idx_q == IDX_W'(NCFG - 1)) begin
              phase_d = PH_POLL;
              idx_d   = '0;
            end else begin
              idx_d = idx_q + IDX_W'(1);
            end
          end
          PH_POLL: begin
            if (word[EOC_BIT] == EOC_READY) begin
              phase_d = PH_RES;
              idx_d   = '0;
            end
          end
          PH_RES: begin
            if (idx_q == IDX_W'(NRES - 1)) begin
              phase_d = PH_IDLE;
              done_d  = 1'b1;
              out_ld  = 1'b1;
            end else begin
              sh_ld = 1'b1;
              idx_d = idx_q + IDX_W'(1);
            end
          end
          default: phase_d = PH_IDLE;
        endcase
      end
    end
  end

  // ---------------- phase controller: registers ----------------
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      wait_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      wait_q  <= wait_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  // shadow copies of the earlier results until the set is complete
  logic [RES_W-1:0] sh_q [NRES-1];

  generate
    for (genvar g = 0; g < NRES - 1; g++) begin : g_shadow
      always_ff @(posedge clk or negedge rst_n_s) begin
        if (!rst_n_s)                              sh_q[g] <= '0;
        else if (sh_ld && idx_q == IDX_W'(g))      sh_q[g] <= word;
      end
    end
  endgenerate

  logic [RES_W-1:0] cap_x_q, cap_y_q, temp_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cap_x_q <= '0;
      cap_y_q <= '0;
      temp_q  <= '0;
    end else if (out_ld) begin
      cap_x_q <= sh_q[0];
      cap_y_q <= sh_q[1];
      temp_q  <= word;
    end
  end

  assign cap_x_o = cap_x_q;
  assign cap_y_o = cap_y_q;
  assign temp_o  = temp_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
  parameter int RES_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid_o,
  input logic [1:0]       cmd_op_o,
  input logic [7:0]       cmd_data_o,
  input logic             cmd_nack_o,
  input logic             eng_done_i,
  input logic             eng_ack_i,
  input logic [RES_W-1:0] cap_x_o,
  input logic [RES_W-1:0] cap_y_o,
  input logic [RES_W-1:0] temp_o,
  input logic             done_o,
  input logic             err_o
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !eng_done_i |=> cmd_valid_o && $stable(cmd_op_o) &&
      $stable(cmd_data_o) && $stable(cmd_nack_o)); // R1

  AST_NACK_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_nack_o |-> cmd_op_o == 2'd2); // R7

  AST_STOP_AFTER_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_op_o == 2'd1 && eng_done_i && !eng_ack_i |=>
      cmd_valid_o && cmd_op_o == 2'd3); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(cap_x_o) && $stable(cap_y_o) && $stable(temp_o)); // R9

  AST_NO_DONE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o)); // R10

  AST_ERR_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !cmd_valid_o); // R11
endmodule

bind acq_sequencer acq_sequencer_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
  .cmd_data_o(cmd_data_o), .cmd_nack_o(cmd_nack_o), .eng_done_i(eng_done_i),
  .eng_ack_i(eng_ack_i), .cap_x_o(cap_x_o), .cap_y_o(cap_y_o), .temp_o(temp_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_acq_sequencer.sv
`timescale 1ns/1ps
module tb_acq_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic cmd_valid, cmd_nack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic eng_done = 1'b0, eng_ack = 1'b1;
  logic [7:0] eng_rdata = 8'h00;
  logic [23:0] cap_x, cap_y, temp;
  logic done, err;

  always #2.5 clk = ~clk;

  acq_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_valid_o(cmd_valid),
    .cmd_op_o(cmd_op), .cmd_data_o(cmd_data), .cmd_nack_o(cmd_nack),
    .eng_done_i(eng_done), .eng_ack_i(eng_ack), .eng_rdata_i(eng_rdata),
    .cap_x_o(cap_x), .cap_y_o(cap_y), .temp_o(temp), .done_o(done), .err_o(err)
  );

  localparam logic [7:0] AW = {7'h48, 1'b0};
  localparam logic [7:0] AR = {7'h48, 1'b1};

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mem [0:15];
  logic [10:0] expq [$];
  string tagq [$];
  int lat = 1, not_ready = 0, poll_cnt = 0, nack_tgt = -1, wr_cnt = 0;
  int widx = 0, ptr = 0, cnt = 0;
  bit busy = 0, run_fail = 0, model_idle = 1, rst_done = 0, start_q = 0, exp_err = 0;
  logic [1:0] cur_op = 2'd0;
  logic [23:0] exp_x = '0, exp_y = '0, exp_t = '0, nxt_x = '0, nxt_y = '0, nxt_t = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [10:0] mk(input logic [1:0] op, input logic nk, input logic [7:0] d);
    return {op, nk, d};
  endfunction

  task automatic push(input logic [10:0] e, input string t);
    expq.push_back(e);
    tagq.push_back(t);
  endtask

  task automatic q_read(input logic [7:0] rg, input int n, input string t);
    push(mk(2'd0, 1'b0, 8'h00), "R1 start");
    push(mk(2'd1, 1'b0, AW), "R2 write address");
    push(mk(2'd1, 1'b0, rg), t);
    push(mk(2'd0, 1'b0, 8'h00), "R1 repeated start");
    push(mk(2'd1, 1'b0, AR), "R2 read address");
    for (int i = 0; i < n; i++) push(mk(2'd2, (i == n - 1), 8'h00), "R7 read byte nack");
    push(mk(2'd3, 1'b0, 8'h00), "R1 stop");
  endtask

  task automatic q_full(input int nr);
    push(mk(2'd0, 1'b0, 8'h00), "R4 start");
    push(mk(2'd1, 1'b0, AW), "R2 address");
    push(mk(2'd1, 1'b0, 8'hBE), "R4 reset byte");
    push(mk(2'd3, 1'b0, 8'h00), "R4 stop");
    push(mk(2'd0, 1'b0, 8'h00), "R5 start");
    push(mk(2'd1, 1'b0, AW), "R2 address");
    push(mk(2'd1, 1'b0, 8'h0A), "R5 reg0");
    push(mk(2'd1, 1'b0, 8'hA0), "R5 val0");
    push(mk(2'd3, 1'b0, 8'h00), "R5 stop");
    push(mk(2'd0, 1'b0, 8'h00), "R5 start");
    push(mk(2'd1, 1'b0, AW), "R2 address");
    push(mk(2'd1, 1'b0, 8'h0B), "R5 reg1");
    push(mk(2'd1, 1'b0, 8'h01), "R5 val1");
    push(mk(2'd3, 1'b0, 8'h00), "R5 stop");
    for (int p = 0; p <= nr; p++) q_read(8'h00, 1, "R6 status pointer");
    q_read(8'h01, 3, "R7 X pointer");
    q_read(8'h04, 3, "R7 Y pointer");
    q_read(8'h07, 3, "R7 temp pointer");
  endtask

  always @(posedge clk) start_q <= start_i;

  // engine model, reference model and per-cycle comparison
  always @(negedge clk) begin
    bit fin;
    logic [10:0] e;
    string t;
    fin = 1'b0;
    if (rst_done) begin
      if (eng_done) begin
        eng_done = 1'b0;
        busy = 1'b0;
        if (cur_op == 2'd3 && expq.size() == 0 && !model_idle) begin
          fin = 1'b1;
          model_idle = 1'b1;
          if (run_fail) exp_err = 1'b1;
          else begin
            exp_x = nxt_x;
            exp_y = nxt_y;
            exp_t = nxt_t;
          end
        end
      end
      if (start_q && model_idle) begin
        model_idle = 1'b0;
        exp_err = 1'b0;
      end
      check(done == (fin && !run_fail), "R9 done pulse", 32'(done), 32'(fin && !run_fail));
      check(err == exp_err, "R10 R11 error flag", 32'(err), 32'(exp_err));
      check(cap_x == exp_x, "R8 R9 cap_x", 32'(cap_x), 32'(exp_x));
      check(cap_y == exp_y, "R8 R9 cap_y", 32'(cap_y), 32'(exp_y));
      check(temp == exp_t, "R8 R9 temp", 32'(temp), 32'(exp_t));
      if (busy) begin
        if (cnt <= 1) eng_done = 1'b1;
        else cnt--;
      end else if (cmd_valid) begin
        cur_op = cmd_op;
        if (expq.size() == 0) begin
          check(1'b0, "R3 unexpected command", 32'({cmd_op, cmd_nack, cmd_data}), 32'h0);
        end else begin
          e = expq.pop_front();
          t = tagq.pop_front();
          check({cmd_op, cmd_nack, cmd_data} == e, t, 32'({cmd_op, cmd_nack, cmd_data}), 32'(e));
        end
        eng_ack = 1'b1;
        eng_rdata = 8'h00;
        case (cmd_op)
          2'd0: widx = 0;
          2'd1: begin
            wr_cnt++;
            if (widx == 1) ptr = int'(cmd_data);
            widx++;
            if (wr_cnt == nack_tgt) begin
              eng_ack = 1'b0;
              run_fail = 1'b1;
              expq.delete();
              tagq.delete();
              push(mk(2'd3, 1'b0, 8'h00), "R10 stop after refusal");
            end
          end
          2'd2: begin
            if (ptr == 0) begin
              eng_rdata = (poll_cnt < not_ready) ? 8'h07 : 8'hFE;
              poll_cnt++;
            end else begin
              eng_rdata = mem[ptr[3:0]];
              ptr++;
            end
          end
          default: ;
        endcase
        busy = 1'b1;
        cnt = lat;
      end
    end
  end

  task automatic run(input int l, input int nr, input int nt, input logic [7:0] seed, input bit mid);
    lat = l;
    not_ready = nr;
    nack_tgt = nt;
    poll_cnt = 0;
    wr_cnt = 0;
    run_fail = 1'b0;
    for (int i = 0; i < 16; i++) mem[i] = seed + 8'(i * 37);
    nxt_x = {mem[1], mem[2], mem[3]};
    nxt_y = {mem[4], mem[5], mem[6]};
    nxt_t = {mem[7], mem[8], mem[9]};
    q_full(nr);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (mid) begin
      repeat (25) @(negedge clk);
      start_i = 1'b1;   // R3: request while busy must be ignored
      @(negedge clk) start_i = 1'b0;
    end
    repeat (3) @(negedge clk);
    while (!model_idle) @(negedge clk);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R3 sequence complete", 32'(expq.size()), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R3: actual hung expected idle");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rst_done = 1'b1;
    repeat (5) @(negedge clk);
    check(cmd_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R12 reset controls",
          32'({cmd_valid, done, err}), 32'h0);
    check(cap_x == 0 && cap_y == 0 && temp == 0, "R12 reset results", 32'(cap_x | cap_y | temp), 32'h0);
    run(1, 0, -1, 8'h11, 1'b0);   // ready at first poll
    run(3, 3, -1, 8'h5C, 1'b1);   // three not-ready polls, stray start mid-run
    run(2, 0, 1, 8'h22, 1'b0);    // R10: refusal of the very first address byte
    run(1, 0, -1, 8'h93, 1'b0);   // R11: clean run after error clears flag
    run(2, 1, 5, 8'h44, 1'b0);    // R10: refusal of first configuration value
    run(1, 2, 11, 8'h66, 1'b0);   // R10: refusal of read address in first poll
    run(4, 1, -1, 8'hE7, 1'b0);   // slow engine, full run
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule